// File: doc/BRIEF.md
# Thermal Alarm Event Generator

This block watches an active-low alarm line from an external thermal sensor and turns its transitions into interrupt requests for software. The line is first brought into the local clock domain. A polarity control then chooses which transition counts. With polarity clear, the alarm becoming active counts. With polarity set, the alarm returning to inactive counts. Software can therefore take one interrupt when the temperature threshold is crossed, flip the polarity, and take a second interrupt when the condition goes away.

A counted transition sets a sticky status bit, which software clears by writing a one to it. While status and the enable bit are both set, the block drives a level request. A routing bit sends that request to either the system-management interrupt output or the configuration interrupt output. When the system is in a deep sleep state, transitions are ignored. Software sees only the latched status through the register port, never the live alarm level.

The register port is a plain single-cycle write strobe with a combinational read. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `thermal_event_gen`

## Requirements
- R1: With polarity (control bit 1) at 0, a high-to-low transition of `alarm_n` sets status. Status reads 1 at address 1, bit 0, three clock edges after the input changes.
- R2: With polarity at 1, a low-to-high transition of `alarm_n` sets status with the same three-edge latency.
- R3: A transition in the direction the polarity does not select leaves status at 0.
- R4: An interrupt output is high only while status and enable (control bit 0) are both 1. Clearing enable drops the output after the write, while status stays set.
- R5: With routing (control bit 2) at 1, the request appears on `sci_req` and `smi_req` stays low. With routing at 0, the request appears on `smi_req` and `sci_req` stays low.
- R6: While `sleep_deep` is 1 in the cycle a transition is detected, status is not set.
- R7: Writing address 1 with bit 0 set clears status, and writing bit 0 as 0 leaves it unchanged. If a transition is detected in the same cycle as the clearing write, status stays 1.
- R8: Writing a new polarity value while the alarm level is steady does not set status.
- R9: Address 0 reads back the control bits {route, polarity, enable} in bits 2..0. Address 1 reads status in bit 0 with bits 2..1 at 0, and the live alarm level appears in no read field.
- R10: After reset, control and status read 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_n | input | 1 | Asynchronous thermal alarm, low = over threshold |
| sleep_deep | input | 1 | High while the system is in a deep sleep state; suppresses detection |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 3 | Write data |
| reg_rdata | output | 3 | Combinational read data for `reg_addr` |
| smi_req | output | 1 | System-management interrupt request level |
| sci_req | output | 1 | Configuration interrupt request level |

## Verification
A change on `alarm_n` passes through two synchronizer flops and then sets status on the third clock edge. The interrupt outputs and the status read follow status in that same cycle. A register write takes effect at the single edge on which its strobe is sampled. The bench drives every input on the falling clock edge and counts exactly three rising edges after an alarm change before it samples. For the set-versus-clear race, it places the clearing strobe in the window between the second and third edges. All results are read on falling edges, well away from the rising edge that updates them.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int REG_W     = 3;
  localparam int BIT_EN    = 0;
  localparam int BIT_POL   = 1;
  localparam int BIT_ROUTE = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic route;
    logic pol;
    logic en;
  } thm_ctrl_t;
endpackage

// File: rtl/thm_sync.sv
module thm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/thm_edge.sv
module thm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pol,
  input  logic sleep,
  output logic prev_lvl,
  output logic hit
);
  logic fall, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b1;
    else        prev_lvl <= lvl;
  end

  // Edges are taken from level history only; polarity just selects one,
  // so a polarity change cannot manufacture a transition.
  assign fall = prev_lvl & ~lvl;
  assign rise = ~prev_lvl & lvl;
  assign hit  = ~sleep & (pol ? rise : fall);
endmodule

// File: rtl/thm_regs.sv
module thm_regs
  import thm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             hit,
  output thm_ctrl_t        ctrl,
  output logic             status,
  output logic             clr,
  output logic [REG_W-1:0] rdata
);
  assign clr = wr && (addr == ADDR_STAT) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ctrl <= '0;
    else if (wr && (addr == ADDR_CTRL))   ctrl <= thm_ctrl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status <= 1'b0;
    else if (hit) status <= 1'b1;   // set beats clear
    else if (clr) status <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) rdata = REG_W'(ctrl);
    else                   rdata[0] = status;
  end
endmodule

// File: rtl/thermal_event_gen.sv
module thermal_event_gen
  import thm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alarm_n,
  input  logic             sleep_deep,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             smi_req,
  output logic             sci_req
);
  logic      sync_lvl, prev_lvl, edge_hit, status_q, clr_req, evt_req;
  thm_ctrl_t ctrl;

  thm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(alarm_n), .q(sync_lvl)
  );

  thm_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .pol(ctrl.pol),
    .sleep(sleep_deep), .prev_lvl(prev_lvl), .hit(edge_hit)
  );

  thm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .hit(edge_hit), .ctrl(ctrl), .status(status_q),
    .clr(clr_req), .rdata(reg_rdata)
  );

  assign evt_req = status_q & ctrl.en;
  assign smi_req = evt_req & ~ctrl.route;
  assign sci_req = evt_req &  ctrl.route;
endmodule

// File: rtl/thm_evt_chk.sv
module thm_evt_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_lvl,
  input logic prev_lvl,
  input logic pol,
  input logic en,
  input logic route,
  input logic sleep,
  input logic status,
  input logic hit,
  input logic clr,
  input logic smi,
  input logic sci
);
  AST_FALL_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_lvl && !sync_lvl && !pol && !sleep) |-> hit);            // R1
  AST_RISE_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_lvl && sync_lvl && pol && !sleep) |-> hit);             // R2
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status);                                               // R7
  AST_NO_EN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!smi && !sci));                                       // R4
  AST_ROUTE_SCI: assert property (@(posedge clk) disable iff (!rst_n)
    (status && en && route) |-> (sci && !smi));                    // R5
  AST_ROUTE_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (status && en && !route) |-> (smi && !sci));                   // R5
  AST_SLEEP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !status) |=> !status);                               // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);                                  // R7
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !status);                                    // R7
endmodule

bind thermal_event_gen thm_evt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .prev_lvl(prev_lvl),
  .pol(ctrl.pol), .en(ctrl.en), .route(ctrl.route), .sleep(sleep_deep),
  .status(status_q), .hit(edge_hit), .clr(clr_req),
  .smi(smi_req), .sci(sci_req)
);

// File: tb/tb_thermal_event_gen.sv
module tb_thermal_event_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm_n = 1'b1;
  logic       sleep_deep = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic [2:0] reg_rdata;
  logic       smi_req, sci_req;
  int tests = 0, fails = 0;
  bit done = 0;

  thermal_event_gen dut (.*);

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [2:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic a, output logic [2:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] rv;
    logic st, exp_st;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    rd_reg(1'b0, rv); chk("R10 ctrl", rv, 3'b000);
    rd_reg(1'b1, rv); chk("R10 status", rv, 3'b000);
    chk("R10 req", {1'b0, smi_req, sci_req}, 3'b000);

    // Sweep: route, polarity, enable, edge direction, sleep
    for (int c = 0; c < 32; c++) begin
      logic route, pol, en, dir, slp, start;
      {route, pol, en, dir, slp} = 5'(c);
      start = dir ? 1'b0 : 1'b1;       // dir 1 = rising
      wr_reg(1'b0, 3'b000);
      alarm_n = start;
      tick(4);
      wr_reg(1'b1, 3'b001);
      rd_reg(1'b1, rv); chk("R7 cleared", rv, 3'b000);
      wr_reg(1'b0, {route, pol, en});
      rd_reg(1'b0, rv); chk("R9 ctrl readback", rv, {route, pol, en});
      sleep_deep = slp;
      alarm_n = ~start;
      tick(2);
      rd_reg(1'b1, rv); chk("R1 R2 latency not early", rv, 3'b000);
      tick(1);
      sleep_deep = 1'b0;
      exp_st = !slp && (dir == pol);
      rd_reg(1'b1, rv);
      if (slp)             chk("R6 sleep suppress", rv, {2'b00, exp_st});
      else if (dir != pol) chk("R3 wrong direction", rv, {2'b00, exp_st});
      else if (pol)        chk("R2 rise sets", rv, {2'b00, exp_st});
      else                 chk("R1 fall sets", rv, {2'b00, exp_st});
      chk("R4 R5 smi", {2'b00, smi_req}, {2'b00, exp_st & en & ~route});
      chk("R4 R5 sci", {2'b00, sci_req}, {2'b00, exp_st & en & route});
    end

    // R8: polarity change with steady level
    wr_reg(1'b0, 3'b001);
    alarm_n = 1'b0; tick(4);
    wr_reg(1'b1, 3'b001);
    wr_reg(1'b0, 3'b011); tick(4);
    rd_reg(1'b1, rv); chk("R8 pol to 1", rv, 3'b000);
    wr_reg(1'b0, 3'b001); tick(4);
    rd_reg(1'b1, rv); chk("R8 pol to 0", rv, 3'b000);

    // R7: write 0 keeps status, set wins over clear
    alarm_n = 1'b1; tick(4);
    alarm_n = 1'b0; tick(3);
    rd_reg(1'b1, rv); chk("R1 event", rv, 3'b001);
    rd_reg(1'b1, rv); chk("R9 no live level", rv, 3'b001);
    wr_reg(1'b1, 3'b110);
    rd_reg(1'b1, rv); chk("R7 write 0 keeps", rv, 3'b001);
    wr_reg(1'b0, 3'b011);             // pol 1, en 1, route smi
    alarm_n = 1'b1;
    tick(2);
    wr_reg(1'b1, 3'b001);             // clear races the rise
    rd_reg(1'b1, rv); chk("R7 set wins", rv, 3'b001);
    chk("R5 smi level", {2'b00, smi_req}, 3'b001);
    // R4: removing enable drops request, status kept
    wr_reg(1'b0, 3'b010);
    chk("R4 en off smi", {2'b00, smi_req}, 3'b000);
    rd_reg(1'b1, rv); chk("R4 status kept", rv, 3'b001);
    wr_reg(1'b1, 3'b001);
    rd_reg(1'b1, rv); chk("R7 clear", rv, 3'b000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule